// File: doc/BRIEF.md
# Register-Controlled Pin Bank with Level Interrupts

This block gives a host processor control over a bank of general-purpose pins, up to 32 of them, through a small Wishbone-style slave port. Software can read the sampled pin levels, set what each pin drives and whether its driver is enabled, hand individual output pins over to an auxiliary signal source, and arm per-pin interrupts that fire while a pin sits at a chosen level. One interrupt request line goes to the host.

Input pins are captured into a register. By default the capture uses the bus clock. A control bit can switch capture to an external sampling clock. That clock is resynchronized into the bus clock domain, and either its rising or its falling edge is chosen as the capture point. The whole block runs on one clock. The bus port is a plain register interface and has no streaming handshake. Every access that is started is acknowledged on the next cycle, so the slave never applies back-pressure.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all registers read zero, `pin_out` is zero, `pin_oe_n` is all ones, and `irq` and `bus_ack` are low.
- R2: A cycle with `bus_cyc` and `bus_stb` high and `bus_ack` low is acknowledged in the next cycle, and `bus_ack` stays high for exactly one cycle. Read data is valid while `bus_ack` is high. The word index `bus_adr[4:2]` selects the register: 0 input, 1 output value, 2 output enable, 3 interrupt enable, 4 polarity, 5 auxiliary select, 6 control, 7 interrupt status. Bits above the pin count read zero. A write to index 0 has no effect.
- R3: When control bit 2 is clear, the input register takes the pin levels on every bus clock edge.
- R4: When control bit 2 is set and bit 3 is clear, the input register loads the pins only on a rising edge of `ext_clk`. Pin changes with no such edge, and falling edges, leave it unchanged.
- R5: When control bits 2 and 3 are both set, the input register loads the pins only on a falling edge of `ext_clk`, and a rising edge leaves it unchanged.
- R6: Each bit of `pin_out` equals the `aux_in` bit where the auxiliary-select bit is 1, and the output-value bit where it is 0.
- R7: `pin_oe_n` is the bitwise inverse of the output-enable register.
- R8: A status bit is set while its interrupt-enable bit is 1 and its sampled input matches the polarity bit (0 means triggered when low, 1 means triggered when high). A pin whose interrupt-enable bit is 0 never sets its status bit.
- R9: Status bits are sticky. A write to the status register replaces them with the written value, and any trigger active in that cycle is ORed in afterwards.
- R10: `irq` is a registered copy of (control bit 0 AND any status bit set). Control bit 1 (pending) is set by hardware whenever that condition holds, and a control write loads it from the written data.
- R11: `irq` is never high in a cycle that follows a cycle where control bit 0 was clear.
- R12: Writing zero to the control register drops `irq` one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, the only clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_adr | input | 5 | Byte address, bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| pin_in | input | 32 | Pin levels from the pads |
| ext_clk | input | 1 | External sampling clock, asynchronous |
| aux_in | input | 32 | Alternative output source per pin |
| pin_out | output | 32 | Pin output values |
| pin_oe_n | output | 32 | Active-low pin output enables |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bus-clock sampling path is driven with random pin words. A stale or shifted capture would show up as a mismatch on read-back. The output mux is driven with independent random auxiliary data, select masks and output words, which separates a swapped mux polarity from a plain pass-through. Directed external-clock sequences change the pins with no edge, then apply the edge that is not selected, then the one that is. These separate capture on the wrong edge from capture on any change. The interrupt sequences use low and high polarity, masked and unmasked pins, and the global enable on and off. They also write the status register while a trigger is still present, which separates sticky status from status that only follows the trigger.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    RG_IN    = 3'd0,
    RG_OUT   = 3'd1,
    RG_OE    = 3'd2,
    RG_INTE  = 3'd3,
    RG_PTRIG = 3'd4,
    RG_AUX   = 3'd5,
    RG_CTRL  = 3'd6,
    RG_INTS  = 3'd7
  } reg_sel_e;

  localparam int CTRL_W = 4;

  // packed: ie is bit 0, pend bit 1, eclk bit 2, neg bit 3
  typedef struct packed {
    logic neg;
    logic eclk;
    logic pend;
    logic ie;
  } ctrl_t;

endpackage

// File: rtl/gpio_in_capture.sv
module gpio_in_capture #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         ext_clk,
  input  logic         use_ext,
  input  logic         on_fall,
  output logic [W-1:0] in_q
);
  localparam int SH = SYNC + 1;

  logic [SH-1:0] sh_q;
  logic          synced, prev, rise, fall, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH-2:0], ext_clk};
  end

  assign synced = sh_q[SYNC-1];
  assign prev   = sh_q[SYNC];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;

  always_comb begin
    if (!use_ext)     take = 1'b1;
    else if (on_fall) take = fall;
    else              take = rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    in_q <= '0;
    else if (take) in_q <= pins;
  end

  // R3
  bus_clock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_ext |=> in_q == $past(pins));
  // R5
  fall_mode_ignores_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && on_fall && synced && !prev) |=> $stable(in_q));
  // R4
  rise_mode_ignores_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && !on_fall && !synced && prev) |=> $stable(in_q));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_q,
  input  logic [W-1:0] inte,
  input  logic [W-1:0] ptrig,
  input  logic         ie,
  input  logic         wr_ints,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ints_q,
  output logic         pend_set,
  output logic         irq_q
);
  logic [W-1:0] hit, base;

  // per-pin level match, generated bit by bit
  for (genvar g = 0; g < W; g++) begin : g_trig
    assign hit[g] = inte[g] & (in_q[g] == ptrig[g]);
  end

  assign base     = wr_ints ? wdata : ints_q;
  assign pend_set = ie & (|ints_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ints_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ints_q <= base | hit;
      irq_q  <= pend_set;
    end
  end

  // R11
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !irq_q);
  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ints |=> (ints_q & $past(ints_q)) == $past(ints_q));
  // R8
  masked_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ints |=> (ints_q & ~$past(ints_q) & ~$past(inte)) == '0);

endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_bank_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  in_q,
  input  logic [W-1:0]  ints_q,
  input  logic          pend_set,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  oe_q,
  output logic [W-1:0]  inte_q,
  output logic [W-1:0]  ptrig_q,
  output logic [W-1:0]  aux_q,
  output ctrl_t         ctrl_q,
  output logic          wr_ints
);
  logic     access, wr, wr_ctrl;
  reg_sel_e sel;
  logic [W-1:0]  sel_val;
  logic [DW-1:0] rd_word;

  assign access  = cyc & stb & ~ack;
  assign wr      = access & we;
  assign sel     = reg_sel_e'(idx);
  assign wr_ctrl = wr && (sel == RG_CTRL);
  assign wr_ints = wr && (sel == RG_INTS);

  always_comb begin
    unique case (sel)
      RG_IN:    sel_val = in_q;
      RG_OUT:   sel_val = out_q;
      RG_OE:    sel_val = oe_q;
      RG_INTE:  sel_val = inte_q;
      RG_PTRIG: sel_val = ptrig_q;
      RG_AUX:   sel_val = aux_q;
      RG_CTRL:  begin sel_val = '0; sel_val[CTRL_W-1:0] = ctrl_q; end
      default:  sel_val = ints_q;
    endcase
    rd_word = '0;
    rd_word[W-1:0] = sel_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      rdata   <= '0;
      out_q   <= '0;
      oe_q    <= '0;
      inte_q  <= '0;
      ptrig_q <= '0;
      aux_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      ack <= access;
      if (access && !we) rdata <= rd_word;
      if (wr) begin
        case (sel)
          RG_OUT:   out_q   <= wdata[W-1:0];
          RG_OE:    oe_q    <= wdata[W-1:0];
          RG_INTE:  inte_q  <= wdata[W-1:0];
          RG_PTRIG: ptrig_q <= wdata[W-1:0];
          RG_AUX:   aux_q   <= wdata[W-1:0];
          RG_CTRL:  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
          default:  ;
        endcase
      end
      if (!wr_ctrl && pend_set) ctrl_q.pend <= 1'b1;
    end
  end

  // R2
  ack_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);
  // R2
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pend && !wr_ctrl) |=> ctrl_q.pend);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [4:0]    bus_adr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  input  logic [W-1:0]  pin_in,
  input  logic          ext_clk,
  input  logic [W-1:0]  aux_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe_n,
  output logic          irq
);
  logic [W-1:0] in_q, ints_q, out_q, oe_q, inte_q, ptrig_q, aux_q;
  ctrl_t        ctrl_q;
  logic         pend_set, wr_ints;

  gpio_bus_regs #(.W(W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cyc(bus_cyc), .stb(bus_stb), .we(bus_we), .idx(bus_adr[4:2]),
    .wdata(bus_wdata), .in_q(in_q), .ints_q(ints_q), .pend_set(pend_set),
    .ack(bus_ack), .rdata(bus_rdata),
    .out_q(out_q), .oe_q(oe_q), .inte_q(inte_q), .ptrig_q(ptrig_q),
    .aux_q(aux_q), .ctrl_q(ctrl_q), .wr_ints(wr_ints)
  );

  gpio_in_capture #(.W(W), .SYNC(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .pins(pin_in), .ext_clk(ext_clk),
    .use_ext(ctrl_q.eclk), .on_fall(ctrl_q.neg), .in_q(in_q)
  );

  gpio_irq_unit #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .in_q(in_q), .inte(inte_q), .ptrig(ptrig_q),
    .ie(ctrl_q.ie), .wr_ints(wr_ints), .wdata(bus_wdata[W-1:0]),
    .ints_q(ints_q), .pend_set(pend_set), .irq_q(irq)
  );

  assign pin_out  = (aux_in & aux_q) | (out_q & ~aux_q);
  assign pin_oe_n = ~oe_q;

  // R7
  oe_write_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb && bus_we && !bus_ack && bus_adr[4:2] == 3'd2)
      |=> pin_oe_n == ~$past(bus_wdata[W-1:0]));
  // R12
  ctrl_clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb && bus_we && !bus_ack && bus_adr[4:2] == 3'd6 && bus_wdata[0] == 1'b0)
      |=> ##1 !irq);

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [4:0]  bus_adr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack, ext_clk = 0, irq;
  logic [W-1:0] pin_in = '0, aux_in = '0, pin_out, pin_oe_n;

  int total = 0, bad = 0;

  gpio_irq_bank #(.W(W)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .pin_in(pin_in),
    .ext_clk(ext_clk), .aux_in(aux_in), .pin_out(pin_out),
    .pin_oe_n(pin_oe_n), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mux_model(logic [31:0] a, logic [31:0] s, logic [31:0] o);
    return (a & s) | (o & ~s);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = {idx, 2'b00}; bus_wdata = d;
    @(negedge clk);
    if (!bus_ack) begin total++; bad++; $display("FAIL R2: actual=ack0 expected=ack1"); end
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic bus_rd(logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = {idx, 2'b00};
    @(negedge clk);
    if (!bus_ack) begin total++; bad++; $display("FAIL R2: actual=ack0 expected=ack1"); end
    d = bus_rdata;
    bus_cyc = 0; bus_stb = 0;
  endtask

  initial begin
    tick(200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, b, c, s, o;
    int seed;
    seed = $urandom(32'h1f2e3d4c);

    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 ack", {31'd0, bus_ack}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe_n", pin_oe_n, 32'hFFFF_FFFF);
    for (int k = 1; k < 8; k++) begin
      bus_rd(3'(k), rd);
      chk("R1 reg", rd, 0);
    end

    // R2 register read-back, random data
    for (int k = 0; k < 10; k++) begin
      for (int r = 1; r < 6; r++) begin
        a = $urandom;
        bus_wr(3'(r), a);
        bus_rd(3'(r), rd);
        chk("R2 readback", rd, a);
      end
    end
    // R2 ack is a single pulse even if strobe is held
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = 5'd4;
    @(negedge clk); chk("R2 ack high", {31'd0, bus_ack}, 1);
    @(negedge clk); chk("R2 ack pulse", {31'd0, bus_ack}, 0);
    bus_cyc = 0; bus_stb = 0;
    // R2 write to input register ignored
    pin_in = 32'h0F0F_1234;
    bus_wr(3'd0, 32'hDEAD_BEEF);
    tick(2);
    bus_rd(3'd0, rd);
    chk("R2 in write ignored", rd, 32'h0F0F_1234);

    // R3 bus-clock sampling, random pins
    bus_wr(3'd6, 0);
    for (int k = 0; k < 20; k++) begin
      a = $urandom; pin_in = a;
      tick(2);
      bus_rd(3'd0, rd);
      chk("R3 in follows pins", rd, a);
    end

    // R6 output mux, R7 enable inversion
    for (int k = 0; k < 20; k++) begin
      a = $urandom; s = $urandom; o = $urandom;
      aux_in = a;
      bus_wr(3'd5, s);
      bus_wr(3'd1, o);
      tick(1);
      chk("R6 pin_out", pin_out, mux_model(a, s, o));
      b = $urandom;
      bus_wr(3'd2, b);
      tick(1);
      chk("R7 pin_oe_n", pin_oe_n, ~b);
    end
    bus_wr(3'd5, 32'hFFFF_FFFF);
    aux_in = 32'h5555_AAAA; tick(1);
    chk("R6 all aux", pin_out, 32'h5555_AAAA);

    // R4 rising-edge capture
    a = 32'h1111_0000; b = 32'h2222_0000; c = 32'h3333_0000;
    pin_in = a; tick(2);
    ext_clk = 0;
    bus_wr(3'd6, 32'h4);
    pin_in = b; tick(5);
    bus_rd(3'd0, rd); chk("R4 no edge holds", rd, a);
    ext_clk = 1; tick(5);
    bus_rd(3'd0, rd); chk("R4 rise captures", rd, b);
    pin_in = c; ext_clk = 0; tick(5);
    bus_rd(3'd0, rd); chk("R4 fall ignored", rd, b);
    ext_clk = 1; tick(5);
    bus_rd(3'd0, rd); chk("R4 second rise", rd, c);

    // R5 falling-edge capture (ext_clk is high now)
    bus_wr(3'd6, 32'hC);
    pin_in = a; ext_clk = 0; tick(5);
    bus_rd(3'd0, rd); chk("R5 fall captures", rd, a);
    pin_in = b; ext_clk = 1; tick(5);
    bus_rd(3'd0, rd); chk("R5 rise ignored", rd, a);
    pin_in = c; tick(5);
    bus_rd(3'd0, rd); chk("R5 no edge holds", rd, a);
    ext_clk = 0; tick(5);
    bus_rd(3'd0, rd); chk("R5 fall again", rd, c);

    // Interrupts
    bus_wr(3'd6, 0);
    pin_in = 32'hFFFF_FFFF;
    bus_wr(3'd3, 0); bus_wr(3'd4, 0); bus_wr(3'd7, 0);
    tick(3);
    pin_in = 32'h0; tick(4);
    bus_rd(3'd7, rd); chk("R8 disabled pins quiet", rd, 0);
    bus_wr(3'd3, 32'h30); tick(3);
    bus_rd(3'd7, rd); chk("R8 low level sets", rd, 32'h30);
    chk("R11 irq off while disabled", {31'd0, irq}, 0);
    bus_rd(3'd6, rd); chk("R10 no pending while disabled", rd, 0);
    bus_wr(3'd6, 32'h1); tick(2);
    chk("R10 irq raised", {31'd0, irq}, 1);
    bus_rd(3'd6, rd); chk("R10 pending set", rd, 32'h3);
    bus_wr(3'd6, 0);
    tick(1);
    chk("R12 irq dropped", {31'd0, irq}, 0);
    pin_in = 32'hFFFF_FFFF; tick(3);
    bus_rd(3'd7, rd); chk("R9 sticky after trigger gone", rd, 32'h30);
    bus_wr(3'd7, 0);
    bus_rd(3'd7, rd); chk("R9 write zero clears", rd, 0);
    // high polarity: bit8 high-active, bit9 low-active, pins all high
    bus_wr(3'd4, 32'h100);
    bus_wr(3'd3, 32'h300); tick(3);
    bus_rd(3'd7, rd); chk("R8 high level sets", rd, 32'h100);
    bus_wr(3'd7, 0);
    bus_rd(3'd7, rd); chk("R9 active trigger re-sets", rd, 32'h100);
    bus_wr(3'd4, 0); tick(2);
    bus_wr(3'd7, 0);
    bus_rd(3'd7, rd); chk("R9 cleared without trigger", rd, 0);
    bus_wr(3'd6, 32'h1); tick(3);
    chk("R10 no irq with empty status", {31'd0, irq}, 0);
    bus_wr(3'd7, 32'h8); tick(2);
    chk("R10 irq from written status", {31'd0, irq}, 1);
    bus_wr(3'd6, 0); tick(1);
    chk("R12 irq dropped again", {31'd0, irq}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule